// File: doc/BRIEF.md
# Interleaved Biphasic Stimulation Sequencer

This block sequences the stimulation switches of a sixteen-electrode-pair implant so that no two channels ever drive current together. A single token travels down a chain of channel cells. While a cell holds the token, it first enables the switches that send current one way through its electrode pair for one clock. It then enables the switches for the reverse direction for one more clock. Then it hands the token to the next cell. The last cell adds one clock in which every electrode is tied to ground to bleed off leftover charge.

The first cell restarts the chain by itself. A NOR of its own activity, the activity of every later stage and the inverted run enable creates a one-cycle start pulse once the whole chain is quiet. A full frame therefore takes 34 clocks: 32 phase clocks, one shorting clock and one idle clock. The clock period alone sets both the phase width and the channel refresh rate. No data stream passes through the block, so all of its pins are plain control and status signals.

Top module: `stim_interleave_seq`

## Requirements
- R1: While reset is asserted (rst_n low), every phase_a and phase_b bit, short_en and busy are 0.
- R2: When the chain is quiet (busy low) and run_en is high at a rising edge, phase_a[0] is high for the cycle that follows that edge.
- R3: For every channel k, phase_a[k] is high for exactly one cycle and phase_b[k] is high in the cycle right after it, also for exactly one cycle.
- R4: In the cycle after phase_b[k] is high (k below 15), phase_a[k+1] is high.
- R5: In the cycle after phase_b[15] is high, short_en is high for exactly one cycle.
- R6: After the short cycle, one cycle follows in which all outputs are low. With run_en held high, consecutive rises of phase_a[0] are 34 cycles apart.
- R7: In every cycle, at most one of the 33 signals phase_a[15:0], phase_b[15:0] and short_en is high.
- R8: busy is high exactly when some phase bit or short_en is high.
- R9: Lowering run_en during a frame does not cut it short: the frame runs through phase_b[15] and the short cycle, and no new frame starts after it.
- R10: With run_en low and the chain quiet, all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock; its period is the phase width |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Allows a new frame to start when the chain is quiet |
| phase_a | output | 16 | Per channel: switch enable for current from electrode A to electrode B |
| phase_b | output | 16 | Per channel: switch enable for the reversed current direction |
| short_en | output | 1 | Ties every electrode to ground for charge removal |
| busy | output | 1 | High while any phase or the short slot is active |

## Verification
The in-design properties assume that run_en is a clean synchronous level, sampled only at rising edges. They also assume that the register chain starts from the cleared state left by reset, so the token is never duplicated or lost. The bench changes run_en only on falling edges. It lowers run_en in the middle of a frame and raises it again only after the chain has gone quiet, so every sequence the bench produces is one the start logic can legally see.

// File: rtl/stim_seq_pkg.sv
package stim_seq_pkg;
  // Switch enables held by one channel cell: forward and reverse phase.
  typedef struct packed {
    logic fwd;
    logic rev;
  } stim_pair_t;

  // Number of clocks per frame for a given channel count.
  function automatic int frame_cycles(input int n_ch);
    return 2 * n_ch + 2;
  endfunction
endpackage

// File: rtl/stim_head_cell.sv
module stim_head_cell
  import stim_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       down_busy,
  output stim_pair_t pair_q,
  output logic       tok_out,
  output logic       cell_busy
);
  logic start_pulse;

  assign cell_busy   = pair_q.fwd | pair_q.rev;
  // Three-input NOR: self activity, downstream activity, inverted run.
  assign start_pulse = ~(cell_busy | down_busy | ~run_en);
  assign tok_out     = pair_q.rev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
    end else begin
      pair_q.fwd <= start_pulse;
      pair_q.rev <= pair_q.fwd;
    end
  end

  // R2 / R9: a frame only starts on a cycle where run was requested
  p_start_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pair_q.fwd |-> $past(run_en));
  // R3: forward phase of the first cell is a single clock
  p_head_fwd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_q.fwd |=> !pair_q.fwd);
  // R3: reverse phase follows forward phase
  p_head_rev_after_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_q.fwd |=> pair_q.rev);
endmodule

// File: rtl/stim_mid_cell.sv
module stim_mid_cell
  import stim_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_in,
  output stim_pair_t pair_q,
  output logic       tok_out,
  output logic       cell_busy
);
  assign cell_busy = pair_q.fwd | pair_q.rev;
  assign tok_out   = pair_q.rev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
    end else begin
      pair_q.fwd <= tok_in;
      pair_q.rev <= pair_q.fwd;
    end
  end

  // R4: forward phase is entered only from the previous cell's reverse phase
  p_fwd_from_prev_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_q.fwd |-> $past(tok_in));
  // R3: reverse phase is entered only from this cell's forward phase
  p_rev_from_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_q.rev |-> $past(pair_q.fwd));
endmodule

// File: rtl/stim_tail_cell.sv
module stim_tail_cell
  import stim_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_in,
  output stim_pair_t pair_q,
  output logic       short_q,
  output logic       cell_busy
);
  assign cell_busy = pair_q.fwd | pair_q.rev | short_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q  <= '0;
      short_q <= 1'b0;
    end else begin
      pair_q.fwd <= tok_in;
      pair_q.rev <= pair_q.fwd;
      short_q    <= pair_q.rev;
    end
  end

  // R5: the short slot directly follows the last reverse phase
  p_short_after_rev_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_q.rev |=> short_q);
  // R5: the short slot lasts a single clock
  p_short_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    short_q |=> !short_q);
  // R3: reverse phase of the last cell follows its forward phase
  p_tail_rev_from_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_q.rev |-> $past(pair_q.fwd));
endmodule

// File: rtl/stim_interleave_seq.sv
module stim_interleave_seq
  import stim_seq_pkg::*;
#(
  parameter int N_CH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  output logic [N_CH-1:0] phase_a,
  output logic [N_CH-1:0] phase_b,
  output logic            short_en,
  output logic            busy
);
  localparam int FRAME_LEN = frame_cycles(N_CH);
  localparam int SLOT_CNT  = 2 * N_CH + 1;

  stim_pair_t        pair_q [N_CH];
  logic [N_CH-1:0]   tok;
  logic [N_CH-1:0]   cell_busy;
  logic              down_busy;
  logic              short_q;

  assign down_busy = |cell_busy[N_CH-1:1];

  for (genvar i = 0; i < N_CH; i++) begin : g_cell
    if (i == 0) begin : g_head
      stim_head_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .down_busy (down_busy),
        .pair_q    (pair_q[i]),
        .tok_out   (tok[i]),
        .cell_busy (cell_busy[i])
      );
    end else if (i == N_CH - 1) begin : g_tail
      stim_tail_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_in    (tok[i-1]),
        .pair_q    (pair_q[i]),
        .short_q   (short_q),
        .cell_busy (cell_busy[i])
      );
      assign tok[i] = pair_q[i].rev;
    end else begin : g_mid
      stim_mid_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_in    (tok[i-1]),
        .pair_q    (pair_q[i]),
        .tok_out   (tok[i]),
        .cell_busy (cell_busy[i])
      );
    end
    assign phase_a[i] = pair_q[i].fwd;
    assign phase_b[i] = pair_q[i].rev;
  end

  assign short_en = short_q;
  assign busy     = |cell_busy;

  // Frame position counter used only by the checks below.
  logic [$clog2(FRAME_LEN+1)-1:0] act_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_cnt <= '0;
    else if (busy)    act_cnt <= act_cnt + 1'b1;
    else              act_cnt <= '0;
  end

  // R7: never more than one active switch group
  p_one_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phase_a, phase_b, short_en}));
  // R6: the cycle after the short slot is quiet
  p_idle_after_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(short_en) |-> !busy);
  // R6: an active stretch never exceeds the phases plus the short slot
  p_active_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (act_cnt < SLOT_CNT));
  // R9: once active, the chain stays active until the short slot
  p_no_early_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !short_en) |=> busy);
endmodule

// File: tb/stim_interleave_seq_bench.sv
module stim_interleave_seq_bench;
  localparam int N = 16;
  localparam int FRAME = 2 * N + 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run_en = 1'b0;
  logic [N-1:0] phase_a, phase_b;
  logic         short_en, busy;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int slot = -1;           // -1 quiet, 0..2N-1 phases, 2N short
  bit measure = 1'b0;
  int last_rise = -1;
  bit seen_stop_short = 1'b0;
  bit done = 1'b0;
  logic prev_a0 = 1'b0;

  always #5 clk = ~clk;

  stim_interleave_seq #(.N_CH(N)) u_stim_interleave_seq (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .phase_a(phase_a), .phase_b(phase_b), .short_en(short_en), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  // Behavioural reference: slot index of the frame.
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) slot = -1;
    else if (slot >= 0) begin
      slot = slot + 1;
      if (slot == 2 * N + 1) slot = -1;
    end else if (run_en) slot = 0;
  end

  always @(negedge clk) begin
    logic [N-1:0] ea, eb;
    logic es, eby;
    ea = '0; eb = '0;
    es = (slot == 2 * N);
    eby = (slot >= 0);
    if (slot >= 0 && slot < 2 * N) begin
      if (slot % 2 == 0) ea[slot/2] = 1'b1;
      else               eb[slot/2] = 1'b1;
    end
    if (!rst_n) begin
      chk({phase_a, phase_b, short_en, busy} == '0, "R1 reset",
          {phase_a, phase_b, short_en, busy}, 0);
    end else begin
      chk(phase_a == ea, "R3/R4 phase_a", phase_a, ea);
      chk(phase_b == eb, "R3/R4 phase_b", phase_b, eb);
      chk(short_en == es, "R5 short_en", short_en, es);
      chk(busy == eby, "R8 busy", busy, eby);
      chk($countones({phase_a, phase_b, short_en}) <= 1, "R7 one active",
          $countones({phase_a, phase_b, short_en}), 1);
      if (phase_a[0] && !prev_a0) begin
        if (measure && last_rise >= 0)
          chk(cyc - last_rise == FRAME, "R6 frame length", cyc - last_rise, FRAME);
        last_rise = cyc;
      end
      if (short_en && !run_en) seen_stop_short = 1'b1;
    end
    prev_a0 = phase_a[0];
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_en = 1'b1;
    measure = 1'b1;
    repeat (3 * FRAME + 5) @(negedge clk);
    measure = 1'b0;
    // stop in the middle of a frame
    while (slot != 10) @(negedge clk);
    run_en = 1'b0;
    repeat (2 * FRAME) @(negedge clk);
    chk(seen_stop_short, "R9 frame completes after stop", seen_stop_short, 1);
    chk(!busy && phase_a == '0 && !short_en, "R10 stays quiet",
        {busy, short_en}, 0);
    // restart from quiet
    run_en = 1'b1;
    @(negedge clk);
    chk(phase_a[0] == 1'b1, "R2 start one clock later", phase_a[0], 1);
    repeat (FRAME + 3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule